// File: doc/BRIEF.md
# Channel Connect/Disconnect Controller

This controller decides whether a channel attachment unit is logically present on an I/O channel. While disconnected, the channel's select signal passes around the unit through relays on both the high-priority and the low-priority chain, and the enable lamp is dark. While connected, the relays of one chain feed select into the unit's selection detector. Moves between the two conditions are driven by a front-panel enable/disable switch. Each move completes a two-phase exchange with a host processor: the controller raises a one-cycle interrupt carrying a notice code and waits for a "go" reply. The shared line buffer changes owner only after that reply.

Inside the connected idle loop the controller arbitrates three things each cycle: a pending disable request, a channel selection, and a step of the device status scanner. While disconnected it also serves a test switch, which opens a background loop where the host can order self-tests. Any host interrupt that arrives outside that loop is treated as an unexpected order. When the test switch is set while any relay coil is energised, the unit is torn off the channel at once and parks in a halted state until reset.

Panel switches and the chain choice pass through a synchronizer first. Host and channel-side inputs are taken as already synchronous. All pins are plain level controls and strobes; there is no data stream and no back-pressure.

Top module: `chan_link_ctrl`

## Requirements
- R1: During reset and after it, with all inputs low, coil_feed and coil_open are all zero, lamp_on, buf_to_unit, link_enabled, host_int, err_flag and halted are 0.
- R2: In the disconnected idle state, with the test switch off, host_irq high moves to an error state. The move gives one cycle of host_int with host_note = 2'b11. After that err_flag stays 1 until reset, and the enable switch has no effect (link_enabled stays 0).
- R3: With the test switch on in the disconnected idle state, test_loop goes to 1. In that loop, host_irq with host_order k (k = 0 processor, 1 memory, 2 communication) raises bit k of test_start in the same cycle. host_order = 3 or host_irq low gives 0. The enable switch is ignored in the loop, and clearing the test switch returns to idle.
- R4: A panel switch change acts on the state at the third rising edge after it is applied (two synchronizer stages plus the state register). Enabling first gives a cycle with link_enabled = 1 and host_int high with host_note = 2'b01, then waits. buf_to_unit stays 0 until host_go is seen. It is 1 in the cycle after host_go, with the coils still off, and the coils engage one cycle later.
- R5: When connected, both coil_feed and coil_open are set for exactly one chain: bit 1 (high chain) if prio_high was 1, bit 0 (low chain) if it was 0. lamp_on is 1 exactly when any coil is energised.
- R6: prio_high is sampled only while disconnected. A change while connected leaves the coils unchanged.
- R7: In the connected idle loop a disable request wins over a channel selection, and a selection wins over the scanner. sel_take = sel_det and scan_step = !sel_det while neither disable nor test is pending. Both are 0 from the cycle the synchronized disable request is present.
- R8: Disabling releases coil_feed first, with coil_open still held for one cycle, and then coil_open. Next comes one cycle of host_int with host_note = 2'b10, and link_enabled drops in that cycle. buf_to_unit stays 1 until host_go is seen and is 0 in the cycle after it.
- R9: The test switch while any coil is energised clears every coil, the lamp and buf_to_unit on the state edge and sets halted, which holds until reset. It wins over a simultaneous disable request.
- R10: host_go outside the two waiting states has no effect on buf_to_unit or link_enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Panel enable/disable switch, 1 = enable |
| sw_test | input | 1 | Panel normal/test switch, 1 = test |
| prio_high | input | 1 | Chain choice, 1 = high-priority chain |
| host_irq | input | 1 | Interrupt/order request from the host |
| host_order | input | 2 | Test kind ordered in the test loop |
| host_go | input | 1 | Host "go" reply |
| sel_det | input | 1 | Channel selection detected |
| host_int | output | 1 | One-cycle interrupt to the host |
| host_note | output | 2 | Notice code valid with host_int |
| link_enabled | output | 1 | Enabled status toward the host |
| buf_to_unit | output | 1 | Line buffer owner, 1 = unit, 0 = host |
| coil_feed | output | 2 | Per-chain coil feeding select into the detector |
| coil_open | output | 2 | Per-chain coil opening the bypass path |
| lamp_on | output | 1 | Enable lamp |
| sel_take | output | 1 | Hand-off strobe to channel selection service |
| scan_step | output | 1 | Advance the device status scanner |
| test_loop | output | 1 | Background test loop active |
| test_start | output | 3 | One-hot test order strobe |
| err_flag | output | 1 | Unexpected order seen while disconnected |
| halted | output | 1 | Emergency stop taken |

## Verification
Two collisions matter. In the connected loop, a disable request and a channel selection can land in the same cycle. The bench holds sel_det high while flipping the enable switch, so the synchronized request meets an active selection. It then expects sel_take to fall in exactly that cycle and the release sequence to follow. Test and disable can also coincide: both switches change on the same edge, and the bench expects the halted state with every coil dropped rather than the orderly release.

// File: rtl/chan_link_pkg.sv
package chan_link_pkg;

  typedef enum logic [3:0] {
    ST_DIS_IDLE,
    ST_DIS_TEST,
    ST_ERR_INT,
    ST_DIS_ERR,
    ST_EN_REQ,
    ST_EN_WAIT,
    ST_EN_BUF,
    ST_ENABLED,
    ST_DS_FEED,
    ST_DS_OPEN,
    ST_DS_INT,
    ST_DS_WAIT,
    ST_HALT
  } link_state_t;

  typedef enum logic [1:0] {
    NOTE_NONE    = 2'b00,
    NOTE_ENABLE  = 2'b01,
    NOTE_DISABLE = 2'b10,
    NOTE_UNEXP   = 2'b11
  } note_t;

endpackage

// File: rtl/chan_link_sync.sv
module chan_link_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end

endmodule

// File: rtl/chan_link_fsm.sv
module chan_link_fsm
  import chan_link_pkg::*;
#(
  parameter int N_TESTS = 3,
  localparam int OW = (N_TESTS > 1) ? $clog2(N_TESTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_req,
  input  logic               test_req,
  input  logic               host_irq,
  input  logic [OW-1:0]      host_order,
  input  logic               host_go,
  input  logic               sel_det,
  output logic               host_int,
  output logic [1:0]         host_note,
  output logic               link_enabled,
  output logic               buf_to_unit,
  output logic               feed_on,
  output logic               open_on,
  output logic               sel_take,
  output logic               scan_step,
  output logic               test_loop,
  output logic [N_TESTS-1:0] test_start,
  output logic               err_flag,
  output logic               halted,
  output logic               capture
);

  link_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DIS_IDLE: begin
        if (test_req)      st_d = ST_DIS_TEST;
        else if (host_irq) st_d = ST_ERR_INT;
        else if (en_req)   st_d = ST_EN_REQ;
      end
      ST_DIS_TEST: if (!test_req) st_d = ST_DIS_IDLE;
      ST_ERR_INT:  st_d = ST_DIS_ERR;
      ST_DIS_ERR:  st_d = ST_DIS_ERR;
      ST_EN_REQ:   st_d = ST_EN_WAIT;
      ST_EN_WAIT:  if (host_go) st_d = ST_EN_BUF;
      ST_EN_BUF:   st_d = ST_ENABLED;
      ST_ENABLED: begin
        if (test_req)     st_d = ST_HALT;
        else if (!en_req) st_d = ST_DS_FEED;
      end
      ST_DS_FEED:  st_d = test_req ? ST_HALT : ST_DS_OPEN;
      ST_DS_OPEN:  st_d = ST_DS_INT;
      ST_DS_INT:   st_d = ST_DS_WAIT;
      ST_DS_WAIT:  if (host_go) st_d = ST_DIS_IDLE;
      ST_HALT:     st_d = ST_HALT;
      default:     st_d = ST_DIS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DIS_IDLE;
    else        st_q <= st_d;
  end

  logic loop_free;
  assign loop_free = (st_q == ST_ENABLED) && en_req && !test_req;

  always_comb begin
    unique case (st_q)
      ST_EN_REQ:  host_note = NOTE_ENABLE;
      ST_DS_INT:  host_note = NOTE_DISABLE;
      ST_ERR_INT: host_note = NOTE_UNEXP;
      default:    host_note = NOTE_NONE;
    endcase
  end

  assign host_int     = (st_q == ST_EN_REQ) || (st_q == ST_DS_INT) || (st_q == ST_ERR_INT);
  assign link_enabled = (st_q == ST_EN_REQ) || (st_q == ST_EN_WAIT) || (st_q == ST_EN_BUF) ||
                        (st_q == ST_ENABLED) || (st_q == ST_DS_FEED) || (st_q == ST_DS_OPEN);
  assign buf_to_unit  = (st_q == ST_EN_BUF) || (st_q == ST_ENABLED) || (st_q == ST_DS_FEED) ||
                        (st_q == ST_DS_OPEN) || (st_q == ST_DS_INT) || (st_q == ST_DS_WAIT);
  assign feed_on      = (st_q == ST_ENABLED);
  assign open_on      = (st_q == ST_ENABLED) || (st_q == ST_DS_FEED);
  assign sel_take     = loop_free && sel_det;
  assign scan_step    = loop_free && !sel_det;
  assign test_loop    = (st_q == ST_DIS_TEST);
  assign err_flag     = (st_q == ST_ERR_INT) || (st_q == ST_DIS_ERR);
  assign halted       = (st_q == ST_HALT);
  assign capture      = (st_q == ST_DIS_IDLE) || (st_q == ST_DIS_TEST) ||
                        (st_q == ST_ERR_INT) || (st_q == ST_DIS_ERR);

  always_comb begin
    test_start = '0;
    if (test_loop && host_irq && (int'(host_order) < N_TESTS))
      test_start = N_TESTS'(1) << host_order;
  end

  // R4: buffer goes to the unit only right after a go reply
  p_buf_after_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_to_unit) |-> $past(host_go));
  // R8: buffer returns to the host only after go, or on emergency stop
  p_buf_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_to_unit) |-> ($past(host_go) || halted));
  // R2: every interrupt is a single-cycle pulse
  p_int_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_int |=> !host_int);
  // R9: halted is sticky
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R3: at most one test ordered per cycle
  p_test_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(test_start));
  // R7: selection hand-off and scanner step never together
  p_sel_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_take && scan_step));

endmodule

// File: rtl/chan_link_relay.sv
module chan_link_relay #(
  parameter int N_CHAINS = 2,
  localparam int CW = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                prio_high,
  input  logic                feed_on,
  input  logic                open_on,
  output logic [N_CHAINS-1:0] coil_feed,
  output logic [N_CHAINS-1:0] coil_open,
  output logic                lamp_on
);

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_q <= '0;
    else if (capture) chain_q <= prio_high ? CW'(N_CHAINS-1) : '0;
  end

  for (genvar i = 0; i < N_CHAINS; i++) begin : g_chain
    assign coil_feed[i] = feed_on && (chain_q == CW'(i));
    assign coil_open[i] = open_on && (chain_q == CW'(i));
  end

  assign lamp_on = (|coil_feed) || (|coil_open);

  // R5: feed coil never energised without its bypass-open coil
  p_feed_needs_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|coil_feed) |-> (coil_open & coil_feed) == coil_feed);
  // R5: only one chain is ever driven
  p_one_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coil_open));
  // R6: chain choice frozen while coils stay engaged
  p_chain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|coil_open) && $past(|coil_open)) |-> $stable(coil_open));

endmodule

// File: rtl/chan_link_ctrl.sv
module chan_link_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int N_TESTS     = 3,
  parameter int N_CHAINS    = 2,
  localparam int OW = (N_TESTS > 1) ? $clog2(N_TESTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_enable,
  input  logic                sw_test,
  input  logic                prio_high,
  input  logic                host_irq,
  input  logic [OW-1:0]       host_order,
  input  logic                host_go,
  input  logic                sel_det,
  output logic                host_int,
  output logic [1:0]          host_note,
  output logic                link_enabled,
  output logic                buf_to_unit,
  output logic [N_CHAINS-1:0] coil_feed,
  output logic [N_CHAINS-1:0] coil_open,
  output logic                lamp_on,
  output logic                sel_take,
  output logic                scan_step,
  output logic                test_loop,
  output logic [N_TESTS-1:0]  test_start,
  output logic                err_flag,
  output logic                halted
);

  logic [2:0] sw_s;
  logic       feed_on, open_on, capture;

  chan_link_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({prio_high, sw_test, sw_enable}),
    .q(sw_s)
  );

  chan_link_fsm #(.N_TESTS(N_TESTS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .en_req(sw_s[0]), .test_req(sw_s[1]),
    .host_irq(host_irq), .host_order(host_order), .host_go(host_go),
    .sel_det(sel_det),
    .host_int(host_int), .host_note(host_note),
    .link_enabled(link_enabled), .buf_to_unit(buf_to_unit),
    .feed_on(feed_on), .open_on(open_on),
    .sel_take(sel_take), .scan_step(scan_step),
    .test_loop(test_loop), .test_start(test_start),
    .err_flag(err_flag), .halted(halted), .capture(capture)
  );

  chan_link_relay #(.N_CHAINS(N_CHAINS)) u_relay (
    .clk(clk), .rst_n(rst_n),
    .capture(capture), .prio_high(sw_s[2]),
    .feed_on(feed_on), .open_on(open_on),
    .coil_feed(coil_feed), .coil_open(coil_open), .lamp_on(lamp_on)
  );

  // R4: relays only ever engage with the line buffer on the unit side
  p_coils_need_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|coil_open) |-> buf_to_unit);

endmodule

// File: tb/test_chan_link_ctrl.sv
module test_chan_link_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_enable, sw_test, prio_high, host_irq, host_go, sel_det;
  logic [1:0] host_order;
  logic host_int, link_enabled, buf_to_unit, lamp_on, sel_take, scan_step;
  logic test_loop, err_flag, halted;
  logic [1:0] host_note, coil_feed, coil_open;
  logic [2:0] test_start;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_link_ctrl i_chan_link_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .sw_test(sw_test),
    .prio_high(prio_high), .host_irq(host_irq), .host_order(host_order),
    .host_go(host_go), .sel_det(sel_det), .host_int(host_int),
    .host_note(host_note), .link_enabled(link_enabled),
    .buf_to_unit(buf_to_unit), .coil_feed(coil_feed), .coil_open(coil_open),
    .lamp_on(lamp_on), .sel_take(sel_take), .scan_step(scan_step),
    .test_loop(test_loop), .test_start(test_start), .err_flag(err_flag),
    .halted(halted)
  );

  function automatic logic [2:0] exp_test(logic irq, logic [1:0] ord);
    return (irq && ord < 2'd3) ? (3'b001 << ord) : 3'b000;
  endfunction

  function automatic logic [1:0] exp_chain(logic hi, logic on);
    return on ? (hi ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sw_enable = 0; sw_test = 0; prio_high = 0;
    host_irq = 0; host_go = 0; sel_det = 0; host_order = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 coils", {coil_feed, coil_open}, 4'h0);
    chk("R1 lamp/buf/en", {lamp_on, buf_to_unit, link_enabled}, 3'b000);
    chk("R1 int/err/halt", {host_int, err_flag, halted}, 3'b000);

    // R3 test loop
    sw_test = 1;
    step(2);
    chk("R3 test loop latency", test_loop, 1'b0);
    step(1);
    chk("R3 test loop entered", test_loop, 1'b1);
    sw_enable = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      host_irq = 1'($urandom % 2);
      host_order = 2'($urandom % 4);
      #2;
      chk("R3 test order", test_start, exp_test(host_irq, host_order));
      chk("R3 enable ignored", link_enabled, 1'b0);
    end
    @(negedge clk);
    host_irq = 0; sw_test = 0; sw_enable = 0;
    step(3);
    chk("R3 test loop left", test_loop, 1'b0);

    // R4/R5 enable sequence, high chain
    prio_high = 1;
    step(3);
    sw_enable = 1;
    step(2);
    chk("R4 sync latency", link_enabled, 1'b0);
    step(1);
    chk("R4 enable notice", {host_int, host_note, link_enabled, buf_to_unit}, 5'b1_01_1_0);
    step(1);
    chk("R4 int single", host_int, 1'b0);
    step(5);
    chk("R4 buffer waits for go", buf_to_unit, 1'b0);
    host_go = 1;
    step(1);
    host_go = 0;
    chk("R4 buffer after go", buf_to_unit, 1'b1);
    chk("R4 coils still off", {coil_feed, coil_open}, 4'h0);
    step(1);
    chk("R5 feed high chain", coil_feed, exp_chain(1'b1, 1'b1));
    chk("R5 open high chain", coil_open, exp_chain(1'b1, 1'b1));
    chk("R5 lamp on", lamp_on, 1'b1);

    // R6 priority frozen while enabled
    prio_high = 0;
    step(5);
    chk("R6 chain unchanged", coil_open, 2'b10);

    // R10 go in enabled loop ignored
    host_go = 1;
    step(2);
    host_go = 0;
    chk("R10 go ignored enabled", {buf_to_unit, link_enabled}, 2'b11);

    // R7 random loop arbitration
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      sel_det = 1'($urandom % 2);
      #2;
      chk("R7 sel_take", sel_take, sel_det);
      chk("R7 scan_step", scan_step, !sel_det);
    end

    // R7 collision: disable and selection together
    @(negedge clk);
    sel_det = 1; sw_enable = 0;
    #2;
    chk("R7 sel before sync", sel_take, 1'b1);
    step(2);
    chk("R7 disable beats select", {sel_take, scan_step}, 2'b00);
    step(1);
    sel_det = 0;
    chk("R8 feed released first", {coil_feed, coil_open, lamp_on}, 5'b00_10_1);
    step(1);
    chk("R8 open released", {coil_feed, coil_open, lamp_on, link_enabled}, 6'b00_00_0_1);
    step(1);
    chk("R8 disable notice", {host_int, host_note, link_enabled, buf_to_unit}, 5'b1_10_0_1);
    step(1);
    chk("R8 int single", host_int, 1'b0);
    step(3);
    chk("R8 buffer waits for go", buf_to_unit, 1'b1);
    host_go = 1;
    step(1);
    host_go = 0;
    chk("R8 buffer to host", buf_to_unit, 1'b0);

    // R5/R6 re-enable on low chain (sampled while disabled)
    step(2);
    sw_enable = 1;
    step(4);
    host_go = 1;
    step(1);
    host_go = 0;
    step(1);
    chk("R6 low chain sampled", coil_open, exp_chain(1'b0, 1'b1));
    chk("R5 feed low chain", coil_feed, 2'b01);

    // R9 emergency stop collides with disable
    sw_test = 1; sw_enable = 0;
    step(2);
    chk("R9 before stop", lamp_on, 1'b1);
    step(1);
    chk("R9 halted", halted, 1'b1);
    chk("R9 coils dropped", {coil_feed, coil_open, lamp_on, buf_to_unit}, 6'h0);
    sw_test = 0;
    step(6);
    chk("R9 halt sticky", halted, 1'b1);

    // R2 unexpected order while disabled
    do_reset();
    host_irq = 1;
    step(1);
    host_irq = 0;
    chk("R2 unexpected notice", {host_int, host_note, err_flag}, 4'b1_11_1);
    step(1);
    chk("R2 error sticky", {host_int, err_flag}, 2'b01);
    sw_enable = 1;
    step(5);
    chk("R2 enable ignored", link_enabled, 1'b0);
    chk("R2 still error", err_flag, 1'b1);

    // R10 go while idle ignored
    do_reset();
    host_go = 1;
    step(3);
    host_go = 0;
    chk("R10 go ignored idle", {buf_to_unit, link_enabled, host_int}, 3'b000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule